// File: doc/BRIEF.md
# Program Trace Window Capture Controller

This block sits beside a processor's debug logic. Every clock it receives a 3-bit instruction status code. Separately, it receives bus addresses that carry a program-trace tag. It stores each tagged address, together with the status code present in the same cycle, in an internal circular trace buffer. Outside logic can read that buffer through an index port. The block also works out the address where the captured instruction stream begins.

It has two capture modes. In back-trace mode, capture is armed right after reset is released, and the first captured address is the start address. In window mode, capture opens after a synchronisation report and closes on the next one. The synchronisation code 011 is shared with other status meanings, so it counts only when the previous cycle's code was 000, 001 or 010. The status code in the cycle after the opening report tells how the start address is found: it is the first captured address, a direct branch target formed from that address, or the second captured address. Tagged addresses reach the bus later than their status reports, because the bus must be won first. For that reason, address capture is counted separately from status sampling.

Top module: `trace_window_ctrl`

## Requirements
- R1: Code 011 is a sync report only when the previous cycle's code was 000, 001 or 010. The status register holds 111 out of reset, so a 011 in the first cycle, or a 011 after any other code, opens no window.
- R2: In back-trace mode (`win_mode_i`=0), `cap_active_o` rises at the first clock edge after reset release. The first tagged address written sets `done_o` and becomes `start_addr_o`. Later writes do not change it.
- R3: In window mode, `cap_active_o` rises at the clock edge that ends the cycle holding a valid sync report. A tagged address in that cycle, or before it, is not written.
- R4: While capturing in window mode, the next valid sync report closes the window. A tagged address in that cycle is not written. `cap_active_o` falls and `done_o` rises at that edge, and nothing more is written until a clear.
- R5: If the code in the cycle after the opening report is 001 (sequential), the start address is the first captured address.
- R6: If that code is 110 (direct branch taken), the start address is the first captured address minus 4 plus the `br_off_i` value sampled in that same cycle.
- R7: If that code is 101 (indirect branch taken), the start address is the second captured address.
- R8: Any other code in that cycle, or too few captured addresses (none for 001/110, fewer than two for 101), sets `err_o` together with `done_o`. In that case `start_addr_o` stays 0.
- R9: Each write stores the tagged address and the current status at index `buf_idx_o`, which then advances by one. `rd_data_o` returns entry `rd_idx_i` as {status[2:0], address}.
- R10: The buffer holds 64 entries. The write after index 63 goes to index 0, and `wrap_o` becomes 1 and stays 1.
- R11: `done_o`, `err_o` and `start_addr_o` hold until `clear_i` or reset. A one-cycle `clear_i` returns the controller, pointer, wrap flag and results to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_mode_i | input | 1 | 1 = window mode, 0 = back-trace mode; held static |
| clear_i | input | 1 | Synchronous clear of the capture session |
| status_i | input | 3 | Per-cycle instruction status code |
| tag_valid_i | input | 1 | A program-trace tagged address is on the bus |
| tag_addr_i | input | 32 | Tagged bus address |
| br_off_i | input | 32 | Direct branch offset, sampled in the cycle after the opening report |
| rd_idx_i | input | 6 | Trace buffer read index |
| cap_active_o | output | 1 | Capture is armed |
| buf_we_o | output | 1 | Buffer write in this cycle |
| buf_idx_o | output | 6 | Current write index |
| buf_addr_o | output | 32 | Address being written |
| buf_stat_o | output | 3 | Status being written |
| rd_data_o | output | 35 | Buffer entry at `rd_idx_i`, {status, address} |
| wrap_o | output | 1 | Buffer has wrapped |
| done_o | output | 1 | Session finished, result valid |
| err_o | output | 1 | Window start address could not be resolved |
| start_addr_o | output | 32 | Computed start address |

## Verification
Context detection errors surface within one cycle. A 011 accepted without a valid predecessor raises `cap_active_o` at the next edge. A real report that is missed leaves it low, and a missed closing report leaves `done_o` low after the window. A wrong captured-address count or a wrong latched code shows up only at the closing edge, as a wrong `start_addr_o` or a spurious `err_o`. So the bench checks that result for every start-address branch and for short captures. Pointer faults show on `buf_idx_o` and `wrap_o` right after each write, and on the readback of entries 0 and 63.

// File: rtl/twc_pkg.sv
package twc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_FIN  = 2'd2
  } twc_state_e;

  localparam logic [2:0] CODE_SYNC = 3'b011;
  localparam logic [2:0] CODE_SEQ  = 3'b001;
  localparam logic [2:0] CODE_DIRB = 3'b110;
  localparam logic [2:0] CODE_INDB = 3'b101;
  localparam logic [2:0] CODE_RST  = 3'b111;

  // A predecessor allows a sync report only if it is 000, 001 or 010
  function automatic logic sync_pred_ok(logic [2:0] prev);
    return (prev[2] == 1'b0) && (prev != CODE_SYNC);
  endfunction

  // Number of captured addresses the start calculation needs for a code
  function automatic logic [1:0] addr_need(logic [2:0] code);
    case (code)
      CODE_SEQ, CODE_DIRB: return 2'd1;
      CODE_INDB:           return 2'd2;
      default:             return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/twc_sync_detect.sv
module twc_sync_detect
  import twc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] status_i,
  output logic       sync_hit_o,
  output logic [2:0] prev_o
);

  logic [2:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= CODE_RST;
    else        prev_q <= status_i;
  end

  assign prev_o     = prev_q;
  assign sync_hit_o = (status_i == CODE_SYNC) && sync_pred_ok(prev_q);

  // R1: a hit must never follow a 011 or 1xx code
  assert_sync_context_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit_o |-> (prev_q != CODE_SYNC) && !prev_q[2]);

endmodule

// File: rtl/twc_trace_buf.sv
module twc_trace_buf #(
  parameter int AW    = 32,
  parameter int SW    = 3,
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH),
  localparam int EW   = AW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] stat_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [PW-1:0] idx_o,
  output logic          wrap_o,
  output logic [EW-1:0] rd_data_o
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr_q;
  logic          wrap_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else if (we_i) begin
      if (ptr_q == LAST) begin
        ptr_q  <= '0;
        wrap_q <= 1'b1;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[ptr_q] <= {stat_i, addr_i};
  end

  assign idx_o     = ptr_q;
  assign wrap_o    = wrap_q;
  assign rd_data_o = mem[rd_idx_i];

  // R10: writing the last slot lands the pointer on zero with wrap set
  assert_wrap_to_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !clr_i && ptr_q == LAST) |=> (ptr_q == '0) && wrap_q);

  // R9: pointer moves by exactly one per write, never without one
  assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !clr_i) |=> $stable(ptr_q));

endmodule

// File: rtl/twc_window_calc.sv
module twc_window_calc
  import twc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          win_mode_i,
  input  logic          vf2_take_i,
  input  logic [2:0]    status_i,
  input  logic [AW-1:0] br_off_i,
  input  logic          cap_we_i,
  input  logic [AW-1:0] cap_addr_i,
  input  logic          close_i,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] start_o
);

  localparam logic [AW-1:0] INSN_BYTES = AW'(4);

  logic [2:0]    vf2_q;
  logic [AW-1:0] off_q;
  logic [AW-1:0] t1_q, t2_q;
  logic [1:0]    cnt_q;
  logic          done_q, err_q;
  logic [AW-1:0] start_q;

  function automatic logic [AW-1:0] pick_start(logic [2:0] code, logic [AW-1:0] t1,
                                                logic [AW-1:0] t2, logic [AW-1:0] off);
    case (code)
      CODE_DIRB: return t1 - INSN_BYTES + off;
      CODE_INDB: return t2;
      default:   return t1;
    endcase
  endfunction

  logic resolve_ok;
  assign resolve_ok = (addr_need(vf2_q) != 2'd3) && (cnt_q >= addr_need(vf2_q));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      vf2_q   <= '0;
      off_q   <= '0;
      t1_q    <= '0;
      t2_q    <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= '0;
    end else begin
      if (vf2_take_i) begin
        vf2_q <= status_i;
        off_q <= br_off_i;
      end
      if (cap_we_i) begin
        if (cnt_q == 2'd0) t1_q <= cap_addr_i;
        if (cnt_q == 2'd1) t2_q <= cap_addr_i;
        if (cnt_q != 2'd2) cnt_q <= cnt_q + 2'd1;
      end
      if (!win_mode_i && cap_we_i && !done_q) begin
        done_q  <= 1'b1;
        start_q <= cap_addr_i;
      end
      if (win_mode_i && close_i) begin
        done_q <= 1'b1;
        if (resolve_ok) start_q <= pick_start(vf2_q, t1_q, t2_q, off_q);
        else            err_q   <= 1'b1;
      end
    end
  end

  assign done_o  = done_q;
  assign err_o   = err_q;
  assign start_o = start_q;

  // R8: an error is only ever reported as part of a finished session
  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> done_q);

  // R11: results are held until a clear
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_i) |=> done_q && $stable(start_q) && $stable(err_q));

  // R8: an unresolved window publishes no address
  assert_err_no_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (start_q == '0));

endmodule

// File: rtl/trace_window_ctrl.sv
module trace_window_ctrl
  import twc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 64,
  localparam int SW   = 3,
  localparam int PW   = $clog2(DEPTH),
  localparam int EW   = AW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_mode_i,
  input  logic          clear_i,
  input  logic [SW-1:0] status_i,
  input  logic          tag_valid_i,
  input  logic [AW-1:0] tag_addr_i,
  input  logic [AW-1:0] br_off_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic          cap_active_o,
  output logic          buf_we_o,
  output logic [PW-1:0] buf_idx_o,
  output logic [AW-1:0] buf_addr_o,
  output logic [SW-1:0] buf_stat_o,
  output logic [EW-1:0] rd_data_o,
  output logic          wrap_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] start_addr_o
);

  twc_state_e state_q;
  logic       vf2_pend_q;

  // Named internal events
  logic       sync_hit;
  logic [2:0] prev_code;
  logic       cap_active;
  logic       win_open;
  logic       win_close;
  logic       cap_we;

  twc_sync_detect u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_i   (status_i),
    .sync_hit_o (sync_hit),
    .prev_o     (prev_code)
  );

  assign cap_active = (state_q == ST_CAPT);
  assign win_open   = (state_q == ST_IDLE) && win_mode_i && sync_hit;
  assign win_close  = cap_active && win_mode_i && sync_hit;
  assign cap_we     = cap_active && tag_valid_i && !win_close;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      state_q    <= ST_IDLE;
      vf2_pend_q <= 1'b0;
    end else begin
      vf2_pend_q <= win_open;
      case (state_q)
        ST_IDLE: if (!win_mode_i || win_open) state_q <= ST_CAPT;
        ST_CAPT: if (win_close) state_q <= ST_FIN;
        default: state_q <= state_q;
      endcase
    end
  end

  twc_trace_buf #(.AW(AW), .SW(SW), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clear_i),
    .we_i      (cap_we),
    .addr_i    (tag_addr_i),
    .stat_i    (status_i),
    .rd_idx_i  (rd_idx_i),
    .idx_o     (buf_idx_o),
    .wrap_o    (wrap_o),
    .rd_data_o (rd_data_o)
  );

  twc_window_calc #(.AW(AW)) u_calc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clear_i),
    .win_mode_i (win_mode_i),
    .vf2_take_i (vf2_pend_q),
    .status_i   (status_i),
    .br_off_i   (br_off_i),
    .cap_we_i   (cap_we),
    .cap_addr_i (tag_addr_i),
    .close_i    (win_close),
    .done_o     (done_o),
    .err_o      (err_o),
    .start_o    (start_addr_o)
  );

  assign cap_active_o = cap_active;
  assign buf_we_o     = cap_we;
  assign buf_addr_o   = tag_addr_i;
  assign buf_stat_o   = status_i;

  // R3: a window only opens after a valid sync report
  assert_open_after_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_mode_i && $rose(cap_active)) |-> $past(sync_hit));

  // R4: a closing report ends capture and finishes the session
  assert_close_finishes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_close && !clear_i) |=> !cap_active && done_o);

  // R2: back-trace mode arms one edge after leaving idle
  assert_back_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_mode_i && state_q == ST_IDLE && !clear_i) |=> cap_active);

  // R4: no buffer write once a session is finished
  assert_no_write_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_mode_i && done_o) |-> !buf_we_o);

endmodule

// File: tb/trace_window_ctrl_tb.sv
module trace_window_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        win_mode;
  logic        clear;
  logic [2:0]  status;
  logic        tag_valid;
  logic [31:0] tag_addr;
  logic [31:0] br_off;
  logic [5:0]  rd_idx;
  logic        cap_active, buf_we, wrap, done, err;
  logic [5:0]  buf_idx;
  logic [31:0] buf_addr, start_addr;
  logic [2:0]  buf_stat;
  logic [34:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  trace_window_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .win_mode_i(win_mode), .clear_i(clear),
    .status_i(status), .tag_valid_i(tag_valid), .tag_addr_i(tag_addr),
    .br_off_i(br_off), .rd_idx_i(rd_idx), .cap_active_o(cap_active),
    .buf_we_o(buf_we), .buf_idx_o(buf_idx), .buf_addr_o(buf_addr),
    .buf_stat_o(buf_stat), .rd_data_o(rd_data), .wrap_o(wrap),
    .done_o(done), .err_o(err), .start_addr_o(start_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drv(input logic [2:0] s, input logic v, input logic [31:0] a);
    status = s; tag_valid = v; tag_addr = a;
  endtask

  task automatic reset_dut(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; win_mode = mode; clear = 1'b0; br_off = '0; rd_idx = '0;
    drv(3'b111, 1'b0, '0);
    repeat (3) step;
    rst_n = 1'b1;
  endtask

  // Window session: open, VF2 cycle, second cycle, close
  task automatic win_case(input string tag, input logic [2:0] vf2, input logic [31:0] off,
                          input int naddr, input logic exp_err, input logic [31:0] exp_start);
    logic [31:0] a1 = 32'h0000_4000;
    logic [31:0] a2 = 32'h0000_8800;
    reset_dut(1'b1);
    chk({tag, " R11 reset done"}, done, 0);
    drv(3'b011, 1'b0, '0); step;
    chk({tag, " R1 011 after 111 ignored"}, cap_active, 0);
    drv(3'b000, 1'b0, '0); step;
    drv(3'b011, 1'b1, 32'hDEAD_0000);
    chk({tag, " R3 sync cycle not written"}, buf_we, 0);
    step;
    chk({tag, " R3 capture open"}, cap_active, 1);
    drv(vf2, naddr >= 1, a1); br_off = off; step;
    br_off = '0;
    drv(3'b000, naddr >= 2, a2); step;
    drv(3'b010, 1'b0, '0); step;
    drv(3'b011, 1'b1, 32'hBAD0_0000);
    chk({tag, " R4 close cycle not written"}, buf_we, 0);
    step;
    chk({tag, " R4 capture closed"}, cap_active, 0);
    chk({tag, " R4 done"}, done, 1);
    chk({tag, " R8 err"}, err, exp_err);
    chk({tag, " start"}, start_addr, exp_start);
    chk({tag, " R9 write count"}, buf_idx, naddr);
    if (naddr >= 1) begin
      rd_idx = 6'd0; #1;
      chk({tag, " R9 entry0"}, rd_data, {vf2, a1});
    end
    drv(3'b001, 1'b1, 32'h1234_5678);
    chk({tag, " R4 no write after done"}, buf_we, 0);
    step;
    chk({tag, " R11 start held"}, start_addr, exp_start);
    drv(3'b111, 1'b0, '0);
  endtask

  task automatic back_case;
    reset_dut(1'b0);
    chk("R2 reset cap_active", cap_active, 0);
    chk("R11 reset idx", buf_idx, 0);
    drv(3'b001, 1'b1, 32'h0000_0111);
    chk("R2 no write before arm", buf_we, 0);
    step;
    chk("R2 armed after first edge", cap_active, 1);
    drv(3'b001, 1'b1, 32'h0000_2000);
    chk("R9 write port addr", buf_addr, 32'h0000_2000);
    chk("R9 write enable", buf_we, 1);
    step;
    chk("R2 done on first capture", done, 1);
    chk("R2 start is first addr", start_addr, 32'h0000_2000);
    drv(3'b110, 1'b1, 32'h0000_3000); step;
    chk("R2 start unchanged", start_addr, 32'h0000_2000);
    chk("R9 idx advanced", buf_idx, 2);
    rd_idx = 6'd1; #1;
    chk("R9 entry1", rd_data, {3'b110, 32'h0000_3000});
    drv(3'b111, 1'b0, '0);
  endtask

  task automatic wrap_case;
    reset_dut(1'b0);
    step;
    for (int i = 0; i < 64; i++) begin
      drv(i[2:0], 1'b1, 32'(i) + 32'h100);
      step;
      if (i == 62) chk("R10 no wrap before 64", wrap, 0);
    end
    chk("R10 wrap set", wrap, 1);
    chk("R10 idx back to 0", buf_idx, 0);
    drv(3'b101, 1'b1, 32'h0000_FFFF); step;
    drv(3'b111, 1'b0, '0);
    rd_idx = 6'd0; #1;
    chk("R10 entry0 overwritten", rd_data, {3'b101, 32'h0000_FFFF});
    rd_idx = 6'd63; #1;
    chk("R9 entry63", rd_data, {3'b111, 32'h0000_013F});
    chk("R10 wrap sticky", wrap, 1);
    clear = 1'b1; step; clear = 1'b0;
    chk("R11 clear done", done, 0);
    chk("R11 clear start", start_addr, 0);
    chk("R11 clear wrap", wrap, 0);
    chk("R11 clear idx", buf_idx, 0);
    chk("R11 clear idle", cap_active, 0);
    step;
    chk("R11 rearm after clear", cap_active, 1);
  endtask

  initial begin
    rst_n = 1'b0; win_mode = 1'b0; clear = 1'b0; br_off = '0; rd_idx = '0;
    drv(3'b111, 1'b0, '0);
    back_case();
    win_case("R5 seq", 3'b001, 32'h0, 2, 1'b0, 32'h0000_4000);
    win_case("R6 direct", 3'b110, 32'h100, 2, 1'b0, 32'h0000_40FC);
    win_case("R7 indirect", 3'b101, 32'h0, 2, 1'b0, 32'h0000_8800);
    win_case("R8 bad code", 3'b100, 32'h0, 2, 1'b1, 32'h0);
    win_case("R8 short indirect", 3'b101, 32'h0, 1, 1'b1, 32'h0);
    win_case("R8 no addr seq", 3'b001, 32'h0, 0, 1'b1, 32'h0);
    wrap_case();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule